// File: doc/BRIEF.md
# Navigation Data Epoch Counter

This block keeps one tracking channel's place inside a one-second interval of the navigation data stream. A fine field counts 1 ms code periods inside a 20 ms data bit. A coarse field counts data bits inside the second. Each code-period strobe advances the fine field. When the fine field wraps, the coarse field advances by one.

Software aligns the count to the received bit stream by writing a preload value. The write carries a mode flag. In immediate mode the value enters the counter on the next clock edge. In deferred mode the value waits in a staging register and enters the counter at the next TIC.

Every TIC copies the running count into a snapshot. The live count can also be read at any time.

Top module: `nav_epoch_counter`

## Requirements
- R1: After reset, the live count, the snapshot and the pending-preload state are all zero.
- R2: The fine field (`live_ms_o`) increments by one on each clock edge where `ms_strobe_i` is high. With no strobe and no preload applied, both live fields hold their values.
- R3: A strobe with the fine field at 19 (MS_PER_BIT-1) sets the fine field to 0 and increments the coarse field.
- R4: A strobe with the fine field at 19 and the coarse field at 49 (BITS_PER_SEC-1) sets both fields to 0.
- R5: A write with `ld_preset_i`=0 loads `ld_bits_i`/`ld_ms_i` into the live count on that clock edge.
- R6: A write with `ld_preset_i`=1 leaves the live count unchanged. It stages the value, and the value loads on the edge of the next cycle where `tic_i` is high.
- R7: On each edge where `tic_i` is high, the snapshot outputs take the live count held just before that edge. At all other edges the snapshot holds.
- R8: A preload applied in the same cycle as a strobe wins. The live count equals the preload value, and the strobe is not counted.
- R9: A staged preload is applied at one TIC only. Later TICs leave the live count alone.
- R10: A field holding a value at or above its terminal value (a preload out of range) goes to 0 on its next step, with the normal carry.
- R11: Every TIC retires a pending staged value. If an immediate-mode write lands in the same cycle, the written value is loaded and the staged value is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ms_strobe_i | input | 1 | One pulse per 1 ms code period |
| tic_i | input | 1 | Periodic snapshot and deferred-load strobe |
| ld_we_i | input | 1 | Preload write strobe |
| ld_preset_i | input | 1 | Mode of the write: 0 immediate, 1 at next TIC |
| ld_bits_i | input | BIT_W (6) | Preload value for the coarse field |
| ld_ms_i | input | MS_W (5) | Preload value for the fine field |
| snap_bits_o | output | BIT_W (6) | TIC snapshot of the coarse field |
| snap_ms_o | output | MS_W (5) | TIC snapshot of the fine field |
| live_bits_o | output | BIT_W (6) | Live coarse field |
| live_ms_o | output | MS_W (5) | Live fine field |

## Verification
The live outputs come straight from the counter registers. A wrong increment, carry or wrap therefore shows at the ports one cycle after the strobe that causes it.

A staging flag stuck high shows up differently. The count does not jump at preload time. Instead it snaps back to the old staged value at the next TIC, possibly many cycles later. For that reason the bench fires repeated TICs after every deferred load.

A snapshot register that captures on the wrong edge, or captures the post-load value, differs from the expected pre-edge value right after the TIC.

// File: rtl/nav_epoch_pkg.sv
package nav_epoch_pkg;
   localparam int MS_PER_BIT_DEF   = 20;
   localparam int BITS_PER_SEC_DEF = 50;

   // Bits needed to hold the values 0 .. modulus-1 (at least one bit).
   function automatic int field_width(input int modulus);
      return (modulus <= 2) ? 1 : $clog2(modulus);
   endfunction
endpackage

// File: rtl/epoch_wrap_stage.sv
module epoch_wrap_stage #(
   parameter int MODULUS = 20,
   parameter int CW      = nav_epoch_pkg::field_width(MODULUS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [CW-1:0] load_val_i,
   input  logic          step_i,
   output logic [CW-1:0] count_o,
   output logic          term_o
);
   localparam logic [CW-1:0] TOP = CW'(MODULUS - 1);

   if (MODULUS < 2) begin : g_bad_mod
      $error("epoch_wrap_stage: MODULUS must be at least 2");
   end
   if ((64'd1 << CW) < 64'(MODULUS)) begin : g_bad_cw
      $error("epoch_wrap_stage: CW too narrow for MODULUS");
   end

   logic [CW-1:0] count_q;
   logic [CW-1:0] inc;

   if ((64'd1 << CW) == 64'(MODULUS)) begin : g_pow2
      // The modulus fills the field, so the natural rollover is the wrap.
      assign inc = count_q + 1'b1;
   end else begin : g_cmp
      assign inc = (count_q >= TOP) ? '0 : count_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       count_q <= '0;
      else if (load_i)  count_q <= load_val_i;
      else if (step_i)  count_q <= inc;
   end

   assign count_o = count_q;
   assign term_o  = (count_q >= TOP);
endmodule

// File: rtl/epoch_preload_stage.sv
module epoch_preload_stage #(
   parameter int DW = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we_i,
   input  logic          preset_i,
   input  logic [DW-1:0] data_i,
   input  logic          tic_i,
   output logic          apply_o,
   output logic [DW-1:0] value_o,
   output logic          pend_o
);
   logic          pend_q;
   logic [DW-1:0] stage_q;
   logic          now_w;
   logic          staged_w;

   assign now_w    = we_i && !preset_i;
   assign staged_w = tic_i && pend_q;
   assign apply_o  = now_w || staged_w;
   assign value_o  = now_w ? data_i : stage_q;
   assign pend_o   = pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q  <= 1'b0;
         stage_q <= '0;
      end else begin
         if (we_i && preset_i) begin
            pend_q  <= 1'b1;
            stage_q <= data_i;
         end else if (tic_i) begin
            pend_q  <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/nav_epoch_counter.sv
module nav_epoch_counter #(
   parameter int MS_PER_BIT   = nav_epoch_pkg::MS_PER_BIT_DEF,
   parameter int BITS_PER_SEC = nav_epoch_pkg::BITS_PER_SEC_DEF,
   parameter int MS_W         = nav_epoch_pkg::field_width(MS_PER_BIT),
   parameter int BIT_W        = nav_epoch_pkg::field_width(BITS_PER_SEC)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ms_strobe_i,
   input  logic             tic_i,
   input  logic             ld_we_i,
   input  logic             ld_preset_i,
   input  logic [BIT_W-1:0] ld_bits_i,
   input  logic [MS_W-1:0]  ld_ms_i,
   output logic [BIT_W-1:0] snap_bits_o,
   output logic [MS_W-1:0]  snap_ms_o,
   output logic [BIT_W-1:0] live_bits_o,
   output logic [MS_W-1:0]  live_ms_o
);
   localparam int TW = BIT_W + MS_W;

   if (MS_PER_BIT < 2 || BITS_PER_SEC < 2) begin : g_bad_radix
      $error("nav_epoch_counter: both radices must be at least 2");
   end

   logic          apply_w;
   logic [TW-1:0] load_w;
   logic          pend_w;
   logic          ms_term_w;
   logic          bit_term_w;
   logic [TW-1:0] snap_q;

   epoch_preload_stage #(.DW(TW)) u_preload (
      .clk      (clk),
      .rst_n    (rst_n),
      .we_i     (ld_we_i),
      .preset_i (ld_preset_i),
      .data_i   ({ld_bits_i, ld_ms_i}),
      .tic_i    (tic_i),
      .apply_o  (apply_w),
      .value_o  (load_w),
      .pend_o   (pend_w)
   );

   epoch_wrap_stage #(.MODULUS(MS_PER_BIT), .CW(MS_W)) u_ms (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (apply_w),
      .load_val_i (load_w[MS_W-1:0]),
      .step_i     (ms_strobe_i),
      .count_o    (live_ms_o),
      .term_o     (ms_term_w)
   );

   epoch_wrap_stage #(.MODULUS(BITS_PER_SEC), .CW(BIT_W)) u_bits (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (apply_w),
      .load_val_i (load_w[TW-1:MS_W]),
      .step_i     (ms_strobe_i && ms_term_w),
      .count_o    (live_bits_o),
      .term_o     (bit_term_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     snap_q <= '0;
      else if (tic_i) snap_q <= {live_bits_o, live_ms_o};
   end

   assign snap_bits_o = snap_q[TW-1:MS_W];
   assign snap_ms_o   = snap_q[MS_W-1:0];
endmodule

module nav_epoch_counter_chk #(
   parameter int MS_W   = 5,
   parameter int BIT_W  = 6,
   parameter int MS_TOP = 20,
   parameter int BIT_TOP = 50
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ms_strobe_i,
   input logic             tic_i,
   input logic             ld_we_i,
   input logic             ld_preset_i,
   input logic [BIT_W-1:0] ld_bits_i,
   input logic [MS_W-1:0]  ld_ms_i,
   input logic [BIT_W-1:0] snap_bits_o,
   input logic [MS_W-1:0]  snap_ms_o,
   input logic [BIT_W-1:0] live_bits_o,
   input logic [MS_W-1:0]  live_ms_o,
   input logic             pend_w,
   input logic             bit_term_w
);
   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!ms_strobe_i && !ld_we_i && !(tic_i && pend_w))
      |=> ($stable(live_ms_o) && $stable(live_bits_o)));

   assert_ms_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ms_strobe_i && !ld_we_i && !(tic_i && pend_w) && live_ms_o == MS_W'(MS_TOP - 1))
      |=> (live_ms_o == '0));

   assert_sec_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ms_strobe_i && !ld_we_i && !(tic_i && pend_w) &&
       live_ms_o == MS_W'(MS_TOP - 1) && live_bits_o == BIT_W'(BIT_TOP - 1))
      |=> (live_bits_o == '0));

   assert_now_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_we_i && !ld_preset_i)
      |=> (live_ms_o == $past(ld_ms_i) && live_bits_o == $past(ld_bits_i)));

   assert_stage_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_we_i && ld_preset_i) |=> pend_w);

   assert_snap_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
      tic_i |=> (snap_ms_o == $past(live_ms_o) && snap_bits_o == $past(live_bits_o)));

   assert_snap_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !tic_i |=> ($stable(snap_ms_o) && $stable(snap_bits_o)));

   assert_retire_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (tic_i && !(ld_we_i && ld_preset_i)) |=> !pend_w);
endmodule

bind nav_epoch_counter nav_epoch_counter_chk #(
   .MS_W(MS_W), .BIT_W(BIT_W), .MS_TOP(MS_PER_BIT), .BIT_TOP(BITS_PER_SEC)
) chk_i (
   .clk(clk), .rst_n(rst_n), .ms_strobe_i(ms_strobe_i), .tic_i(tic_i),
   .ld_we_i(ld_we_i), .ld_preset_i(ld_preset_i), .ld_bits_i(ld_bits_i),
   .ld_ms_i(ld_ms_i), .snap_bits_o(snap_bits_o), .snap_ms_o(snap_ms_o),
   .live_bits_o(live_bits_o), .live_ms_o(live_ms_o), .pend_w(pend_w),
   .bit_term_w(bit_term_w)
);

// File: tb/nav_epoch_counter_tb_top.sv
module nav_epoch_counter_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ms_strobe_i = 1'b0;
   logic       tic_i = 1'b0;
   logic       ld_we_i = 1'b0;
   logic       ld_preset_i = 1'b0;
   logic [5:0] ld_bits_i = '0;
   logic [4:0] ld_ms_i = '0;
   logic [5:0] snap_bits_o;
   logic [4:0] snap_ms_o;
   logic [5:0] live_bits_o;
   logic [4:0] live_ms_o;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   nav_epoch_counter dut_i (
      .clk(clk), .rst_n(rst_n), .ms_strobe_i(ms_strobe_i), .tic_i(tic_i),
      .ld_we_i(ld_we_i), .ld_preset_i(ld_preset_i), .ld_bits_i(ld_bits_i),
      .ld_ms_i(ld_ms_i), .snap_bits_o(snap_bits_o), .snap_ms_o(snap_ms_o),
      .live_bits_o(live_bits_o), .live_ms_o(live_ms_o)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // One clock: drive at negedge, let the edge pass, settle 1 ns.
   task automatic cyc(input bit stb, input bit tic, input bit we,
                      input bit pre, input int bits, input int ms);
      @(negedge clk);
      ms_strobe_i = stb; tic_i = tic; ld_we_i = we; ld_preset_i = pre;
      ld_bits_i = 6'(bits); ld_ms_i = 5'(ms);
      @(posedge clk);
      #1;
      ms_strobe_i = 0; tic_i = 0; ld_we_i = 0;
   endtask

   task automatic chk_live(input string tag, input int bits, input int ms);
      chk({tag, " live bits"}, live_bits_o, bits);
      chk({tag, " live ms"}, live_ms_o, ms);
   endtask

   task automatic chk_snap(input string tag, input int bits, input int ms);
      chk({tag, " snap bits"}, snap_bits_o, bits);
      chk({tag, " snap ms"}, snap_ms_o, ms);
   endtask

   task automatic t_reset_R1;
      #1;
      chk_live("R1 reset", 0, 0);
      chk_snap("R1 reset", 0, 0);
      // No pending value: a TIC must not load anything.
      cyc(0, 1, 0, 0, 0, 0);
      chk_live("R1 no pending", 0, 0);
   endtask

   task automatic t_count_R2;
      for (int i = 0; i < 5; i++) cyc(1, 0, 0, 0, 0, 0);
      chk_live("R2 five strobes", 0, 5);
      for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 0, 0);
      chk_live("R2 idle hold", 0, 5);
      chk_snap("R7 hold without tic", 0, 0);
   endtask

   task automatic t_wrap_R3;
      cyc(0, 0, 1, 0, 3, 19);
      chk_live("R5 immediate load", 3, 19);
      cyc(1, 0, 0, 0, 0, 0);
      chk_live("R3 fine wrap carry", 4, 0);
   endtask

   task automatic t_second_R4;
      cyc(0, 0, 1, 0, 49, 19);
      cyc(1, 0, 0, 0, 0, 0);
      chk_live("R4 second wrap", 0, 0);
   endtask

   task automatic t_preset_R6;
      cyc(0, 0, 1, 0, 2, 2);
      cyc(0, 0, 1, 1, 10, 7);
      chk_live("R6 staged no change", 2, 2);
      cyc(1, 0, 0, 0, 0, 0);
      chk_live("R6 count while staged", 2, 3);
      cyc(0, 1, 0, 0, 0, 0);
      chk_live("R6 applied at tic", 10, 7);
      chk_snap("R7 pre-load snapshot", 2, 3);
      cyc(1, 0, 0, 0, 0, 0);
      cyc(1, 0, 0, 0, 0, 0);
      cyc(0, 1, 0, 0, 0, 0);
      chk_live("R9 second tic no reload", 10, 9);
      chk_snap("R7 second snapshot", 10, 9);
      cyc(0, 1, 0, 0, 0, 0);
      chk_live("R9 third tic no reload", 10, 9);
   endtask

   task automatic t_collide_R8;
      cyc(1, 0, 1, 0, 2, 4);
      chk_live("R8 load beats strobe", 2, 4);
      cyc(0, 0, 1, 1, 7, 1);
      cyc(1, 1, 0, 0, 0, 0);
      chk_live("R8 staged beats strobe", 7, 1);
   endtask

   task automatic t_range_R10;
      cyc(0, 0, 1, 0, 20, 25);
      cyc(1, 0, 0, 0, 0, 0);
      chk_live("R10 fine out of range", 21, 0);
      cyc(0, 0, 1, 0, 55, 19);
      cyc(1, 0, 0, 0, 0, 0);
      chk_live("R10 coarse out of range", 0, 0);
   endtask

   task automatic t_override_R11;
      cyc(0, 0, 1, 1, 1, 1);
      cyc(0, 1, 1, 0, 30, 15);
      chk_live("R11 immediate wins", 30, 15);
      cyc(0, 1, 0, 0, 0, 0);
      chk_live("R11 staged dropped", 30, 15);
      chk_snap("R7 snapshot after override", 30, 15);
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog actual timeout expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      t_reset_R1();
      @(negedge clk) rst_n = 1'b1;
      t_reset_R1();
      t_count_R2();
      t_wrap_R3();
      t_second_R4();
      t_preset_R6();
      t_collide_R8();
      t_range_R10();
      t_override_R11();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule